// File: doc/BRIEF.md
# CAN Fault-Confinement State Tracker

This block keeps the transmit and receive error counters of one CAN channel and derives the channel's fault-confinement state from them: error-active, error-warning, error-passive or bus-off. The counters and the state flags are presented together in one 32-bit status word. A one-cycle event marks every change of the state flags.

When the transmit counter would pass its ceiling, the channel goes bus-off. In bus-off it ignores all counter strobes. It waits for a restart command from the host and then counts idle conditions on the bus, where one idle condition is a run of recessive bits. When the required number of idle conditions has been seen, the counters are cleared and the channel returns to error-active. In the same cycle the block asks the transmit queue to discard the frames that were aborted when bus-off began.

The block also turns each bus-error report from the bit engine into a packed 8-bit capture code with a one-cycle valid pulse.

Top module: `can_fault_tracker`

## Requirements
- R1: `status_o` carries the receive count in bits 7:0 and the transmit count in bits 15:8. Bits 16 and 31:20 are always zero. All bits are zero after reset.
- R2: `tx_inc_i` adds TX_STEP (default 8) to the transmit count and `rx_inc_i` adds RX_STEP (default 1) to the receive count. The receive count saturates at 255. A decrement strobe on either counter subtracts 1 and stops at 0. When increment and decrement are both asserted, the increment wins.
- R3: Bit 17 is set while either count is at least WARN_LIM (default 96). Bit 18 is set while either count is at least PASS_LIM (default 128).
- R4: An increment that would take the transmit count above 255 sets bit 19 (bus-off) and holds the transmit count at 255. While bus-off, every increment and decrement strobe is ignored.
- R5: `state_chg_o` is high for exactly the one cycle in which status bits 19:17 differ from their values in the previous cycle. This includes the return from bus-off.
- R6: `restart_i` has no effect outside bus-off. Recessive bits seen in bus-off before a restart do not count toward recovery.
- R7: After a restart in bus-off, recovery needs IDLE_GOAL idle conditions, each made of IDLE_RUN consecutive recessive bit strobes. A dominant bit strobe restarts the current run, but idle conditions already completed are kept.
- R8: In the cycle in which recovery completes, both counts and bit 19 read zero and `flush_o` is high for one cycle.
- R9: One cycle after `bus_err_i`, `berr_valid_o` pulses and `berr_code_o` holds the packed code: bits 4:0 are the segment, bit 5 is the direction (1 means the error occurred while receiving), and bits 7:6 are the type (00 bit, 01 form, 10 stuff, 11 other). Bus errors are reported in every state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_inc_i | input | 1 | Transmit error strobe |
| tx_dec_i | input | 1 | Transmit success strobe |
| rx_inc_i | input | 1 | Receive error strobe |
| rx_dec_i | input | 1 | Receive success strobe |
| bus_err_i | input | 1 | Bus error report strobe |
| err_type_i | input | 2 | Error type of the report |
| err_rx_i | input | 1 | 1 when the error occurred while receiving |
| err_seg_i | input | 5 | Frame segment where the error occurred |
| bit_stb_i | input | 1 | One pulse per sampled bus bit |
| bit_rec_i | input | 1 | Sampled bit is recessive |
| restart_i | input | 1 | Host restart command |
| status_o | output | 32 | Counters and state flags |
| state_chg_o | output | 1 | State flags changed |
| berr_valid_o | output | 1 | Bus error code valid |
| berr_code_o | output | 8 | Packed bus error code |
| flush_o | output | 1 | Discard aborted frames in the transmit queue |

## Verification
The bench builds the block with IDLE_RUN left at 11 and IDLE_GOAL lowered to 3. With these values a full recovery takes only a few dozen bit strobes, so the bench can cover several paths in one run: recessive bits seen before the restart, a dominant bit in the middle of a run, and the completion cycle itself. It uses the default thresholds and step sizes, so the warning, passive and bus-off edges fall exactly on 96, 128 and the transmit overflow past 255.

// File: rtl/can_fault_tracker.sv
module can_fault_tracker #(
  parameter int TX_STEP   = 8,
  parameter int RX_STEP   = 1,
  parameter int WARN_LIM  = 96,
  parameter int PASS_LIM  = 128,
  parameter int IDLE_RUN  = 11,
  parameter int IDLE_GOAL = 128
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tx_inc_i,
  input  logic        tx_dec_i,
  input  logic        rx_inc_i,
  input  logic        rx_dec_i,
  input  logic        bus_err_i,
  input  logic [1:0]  err_type_i,
  input  logic        err_rx_i,
  input  logic [4:0]  err_seg_i,
  input  logic        bit_stb_i,
  input  logic        bit_rec_i,
  input  logic        restart_i,
  output logic [31:0] status_o,
  output logic        state_chg_o,
  output logic        berr_valid_o,
  output logic [7:0]  berr_code_o,
  output logic        flush_o
);
  localparam int CNT_W  = 8;
  localparam int CNT_MX = (1 << CNT_W) - 1;
  localparam int RUN_W  = $clog2(IDLE_RUN);
  localparam int GOAL_W = $clog2(IDLE_GOAL);
  localparam logic [RUN_W-1:0]  RUN_LAST  = RUN_W'(IDLE_RUN - 1);
  localparam logic [GOAL_W-1:0] GOAL_LAST = GOAL_W'(IDLE_GOAL - 1);

  logic [CNT_W-1:0]  tx_q, rx_q;
  logic              boff_q, rec_q, flush_q, bv_q;
  logic [RUN_W-1:0]  run_q;
  logic [GOAL_W-1:0] idl_q;
  logic [2:0]        flags, flags_q;
  logic [7:0]        code_q;
  logic [CNT_W:0]    tx_sum, rx_sum;

  assign tx_sum = {1'b0, tx_q} + (CNT_W+1)'(TX_STEP);
  assign rx_sum = {1'b0, rx_q} + (CNT_W+1)'(RX_STEP);

  assign flags[0] = (tx_q >= CNT_W'(WARN_LIM)) || (rx_q >= CNT_W'(WARN_LIM));
  assign flags[1] = (tx_q >= CNT_W'(PASS_LIM)) || (rx_q >= CNT_W'(PASS_LIM));
  assign flags[2] = boff_q;

  assign status_o     = {12'd0, flags, 1'b0, tx_q, rx_q};
  assign state_chg_o  = flags != flags_q;
  assign flush_o      = flush_q;
  assign berr_valid_o = bv_q;
  assign berr_code_o  = code_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_q    <= '0;
      rx_q    <= '0;
      boff_q  <= 1'b0;
      rec_q   <= 1'b0;
      run_q   <= '0;
      idl_q   <= '0;
      flags_q <= '0;
      flush_q <= 1'b0;
      bv_q    <= 1'b0;
      code_q  <= '0;
    end else begin
      flags_q <= flags;
      flush_q <= 1'b0;
      bv_q    <= bus_err_i;
      if (bus_err_i) code_q <= {err_type_i, err_rx_i, err_seg_i};
      if (boff_q) begin
        if (!rec_q) begin
          if (restart_i) begin
            rec_q <= 1'b1;
            run_q <= '0;
            idl_q <= '0;
          end
        end else if (bit_stb_i) begin
          if (!bit_rec_i) run_q <= '0;
          else if (run_q == RUN_LAST) begin
            run_q <= '0;
            if (idl_q == GOAL_LAST) begin
              boff_q  <= 1'b0;
              rec_q   <= 1'b0;
              tx_q    <= '0;
              rx_q    <= '0;
              flush_q <= 1'b1;
            end else idl_q <= idl_q + 1'b1;
          end else run_q <= run_q + 1'b1;
        end
      end else begin
        if (tx_inc_i) begin
          if (tx_sum > (CNT_W+1)'(CNT_MX)) begin
            tx_q   <= CNT_W'(CNT_MX);
            boff_q <= 1'b1;
          end else tx_q <= tx_sum[CNT_W-1:0];
        end else if (tx_dec_i && tx_q != '0) tx_q <= tx_q - 1'b1;
        if (rx_inc_i) begin
          if (rx_sum > (CNT_W+1)'(CNT_MX)) rx_q <= CNT_W'(CNT_MX);
          else rx_q <= rx_sum[CNT_W-1:0];
        end else if (rx_dec_i && rx_q != '0) rx_q <= rx_q - 1'b1;
      end
    end
  end

  AST_BOFF_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status_o[19]) |-> state_chg_o); // R5
  AST_BOFF_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (status_o[19] && $past(status_o[19])) |-> $stable(status_o[15:0])); // R4
  AST_EXIT_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(status_o[19]) |-> (status_o[15:0] == 16'd0 && flush_o)); // R8
  AST_EXIT_NEEDS_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(boff_q) |-> $past(rec_q)); // R6
  AST_BERR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err_i |=> berr_valid_o); // R9
  AST_FLUSH_ONLY_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    flush_o |-> !status_o[19] && state_chg_o); // R8
endmodule

// File: tb/tb_can_fault_tracker.sv
module tb_can_fault_tracker;
  localparam int CLK_P = 10;
  localparam int RUN   = 11;
  localparam int GOAL  = 3;

  logic clk = 0, rst_n = 0;
  logic tx_inc = 0, tx_dec = 0, rx_inc = 0, rx_dec = 0, berr = 0, erx = 0;
  logic [1:0] etyp = 0;
  logic [4:0] eseg = 0;
  logic bstb = 0, brec = 0, rst_cmd = 0;
  logic [31:0] status;
  logic chg, bv, flush;
  logic [7:0] bcode;

  can_fault_tracker #(.IDLE_RUN(RUN), .IDLE_GOAL(GOAL)) dut (
    .clk(clk), .rst_n(rst_n), .tx_inc_i(tx_inc), .tx_dec_i(tx_dec),
    .rx_inc_i(rx_inc), .rx_dec_i(rx_dec), .bus_err_i(berr),
    .err_type_i(etyp), .err_rx_i(erx), .err_seg_i(eseg),
    .bit_stb_i(bstb), .bit_rec_i(brec), .restart_i(rst_cmd),
    .status_o(status), .state_chg_o(chg), .berr_valid_o(bv),
    .berr_code_o(bcode), .flush_o(flush));

  always #(CLK_P/2) clk = ~clk;

  typedef struct {
    logic [31:0] st;
    logic        ch, fl, v;
    logic [7:0]  code;
    string       tag;
  } exp_t;
  exp_t q[$];

  int total = 0, bad = 0;
  int m_tx = 0, m_rx = 0, m_idl = 0, m_run = 0;
  bit m_boff = 0, m_rec = 0;
  logic [2:0] m_flags = 0;

  function automatic logic [2:0] mflags();
    mflags = {m_boff, (m_tx >= 128 || m_rx >= 128), (m_tx >= 96 || m_rx >= 96)};
  endfunction

  task automatic step(bit ti, bit td, bit ri, bit rd, bit be, logic [1:0] ty,
                      bit dr, logic [4:0] sg, bit bs, bit br, bit rs, string tag);
    exp_t e;
    logic [2:0] nf;
    @(negedge clk);
    tx_inc = ti; tx_dec = td; rx_inc = ri; rx_dec = rd; berr = be; etyp = ty;
    erx = dr; eseg = sg; bstb = bs; brec = br; rst_cmd = rs;
    @(posedge clk);
    #1;
    e.fl = 0;
    if (m_boff) begin
      if (!m_rec) begin
        if (rs) begin m_rec = 1; m_run = 0; m_idl = 0; end
      end else if (bs) begin
        if (!br) m_run = 0;
        else if (m_run == RUN-1) begin
          m_run = 0;
          if (m_idl == GOAL-1) begin
            m_boff = 0; m_rec = 0; m_tx = 0; m_rx = 0; e.fl = 1;
          end else m_idl++;
        end else m_run++;
      end
    end else begin
      if (ti) begin
        if (m_tx + 8 > 255) begin m_tx = 255; m_boff = 1; end else m_tx += 8;
      end else if (td && m_tx > 0) m_tx--;
      if (ri) m_rx = (m_rx + 1 > 255) ? 255 : m_rx + 1;
      else if (rd && m_rx > 0) m_rx--;
    end
    nf = mflags();
    e.st = {12'd0, nf, 1'b0, m_tx[7:0], m_rx[7:0]};
    e.ch = (nf != m_flags);
    m_flags = nf;
    e.v = be;
    e.code = {ty, dr, sg};
    e.tag = tag;
    q.push_back(e);
  endtask

  task automatic idle(string tag);
    step(0,0,0,0,0,0,0,0,0,0,0,tag);
  endtask
  task automatic bitc(bit r, string tag);
    step(0,0,0,0,0,0,0,0,1,r,0,tag);
  endtask

  initial begin
    forever begin
      @(negedge clk);
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        total++;
        if (status !== e.st || chg !== e.ch || flush !== e.fl || bv !== e.v ||
            (e.v && bcode !== e.code)) begin
          bad++;
          $display("FAIL %s: status=%h chg=%b flush=%b bv=%b code=%h exp status=%h chg=%b flush=%b bv=%b code=%h",
                   e.tag, status, chg, flush, bv, bcode, e.st, e.ch, e.fl, e.v, e.code);
        end
      end
    end
  end

  initial begin
    #(CLK_P * 200000);
    bad++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    total++;
    if (status !== 32'd0 || chg !== 1'b0 || flush !== 1'b0 || bv !== 1'b0) begin
      bad++;
      $display("FAIL R1 reset: status=%h chg=%b flush=%b bv=%b exp 0", status, chg, flush, bv);
    end
    for (int i = 0; i < 5; i++) step(0,0,1,0,0,0,0,0,0,0,0,"R2 rx inc");
    for (int i = 0; i < 6; i++) step(0,0,0,1,0,0,0,0,0,0,0,"R2 rx dec floor");
    for (int i = 0; i < 3; i++) step(1,0,0,0,0,0,0,0,0,0,0,"R1 tx inc field");
    step(1,1,0,0,0,0,0,0,0,0,0,"R2 inc beats dec");
    step(0,1,0,0,0,0,0,0,0,0,0,"R2 tx dec");
    step(0,0,0,0,0,0,0,0,0,0,1,"R6 restart while active");
    bitc(1, "R6 bits while active");
    for (int i = 0; i < 96; i++) step(0,0,1,0,0,0,0,0,0,0,0,"R3 warn edge");
    for (int i = 0; i < 32; i++) step(0,0,1,0,0,0,0,0,0,0,0,"R3 passive edge");
    for (int i = 0; i < 140; i++) step(0,0,1,0,0,0,0,0,0,0,0,"R2 rx saturate");
    for (int i = 0; i < 130; i++) step(0,0,0,1,0,0,0,0,0,0,0,"R5 drop to lower state");
    step(0,0,0,0,1,2'b00,1,5'd3,0,0,0,"R9 bit error rx");
    step(0,0,0,0,1,2'b01,0,5'd31,0,0,0,"R9 form error tx");
    step(0,0,0,0,1,2'b10,1,5'd16,0,0,0,"R9 stuff error");
    step(0,0,0,0,1,2'b11,0,5'd0,0,0,0,"R9 other error");
    idle("R9 no pulse");
    while (!m_boff) step(1,0,0,0,0,0,0,0,0,0,0,"R4 enter bus-off");
    step(1,0,1,0,0,0,0,0,0,0,0,"R4 inc ignored");
    step(0,1,0,1,0,0,0,0,0,0,0,"R4 dec ignored");
    step(0,0,0,0,1,2'b10,0,5'd7,0,0,0,"R9 error in bus-off");
    for (int i = 0; i < 40; i++) bitc(1, "R6 no count before restart");
    step(0,0,0,0,0,0,0,0,0,0,1,"R6 restart");
    for (int i = 0; i < 15; i++) bitc(1, "R7 recessive");
    bitc(0, "R7 dominant restarts run");
    for (int i = 0; i < 8; i++) bitc(1, "R7 partial run");
    bitc(0, "R7 dominant again");
    while (m_boff) bitc(1, "R8 recovery");
    idle("R8 after recovery");
    step(1,0,0,0,0,0,0,0,0,0,0,"R2 counting resumes");
    step(0,0,0,0,0,0,0,0,0,0,1,"R6 restart ignored after");
    repeat (3) @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule